// File: doc/BRIEF.md
# Event-Window Ring Logger

This block records field evidence for a thermally limited appliance. Every record it keeps carries a time stamp from one shared free-running counter. There are three kinds of record. Periodic snapshots of temperature and policy state are taken at a slow base rate. Asynchronous event records log threshold crossings, derating steps, gating changes and reset preparation. Snapshots taken during a burst window run at a faster rate. A critical event opens the burst window, so the sampling density rises around the moment that matters.

Each record goes into a circular buffer and overwrites the oldest entry once the buffer is full. Any entry can be read back through a combinational read port. Every record also carries three counters: protection activations, recoveries, and consecutive failures. An event flagged as preceding an irreversible action gets a one-cycle evidence-done acknowledgement once its record is in the buffer. The system can hold a shutdown or broad reset until that acknowledgement arrives.

The sampling window is a two-state machine. `WIN_BASE` samples every `BASE_PERIOD` cycles. `WIN_BURST` samples every `BURST_PERIOD` cycles. The transition *open* (`WIN_BASE`→`WIN_BURST`) fires on a critical event. The transition *re-arm* (`WIN_BURST`→`WIN_BURST`) fires on a further critical event and restarts the window. The transition *close* (`WIN_BURST`→`WIN_BASE`) fires when the window's last cycle passes with no critical event.

Top module: `evlog_ring`

## Requirements
- R1: After reset, `head_o`=0, `wrap_o`=0, `burst_o`=0, `drop_cnt_o`=0 and `ack_o`=0. The time stamp and the sequence number both start at 0, so the first cycle after reset has time stamp 0.
- R2: The time stamp advances by one every clock cycle. A record stores the time stamp of the cycle in which its input was presented.
- R3: In `WIN_BASE`, a periodic record of type 2'b01 is produced every `BASE_PERIOD` cycles. The first one has time stamp `BASE_PERIOD-1`.
- R4: A valid event with `ev_crit_i`=1 opens or re-arms the burst window. `burst_o` is high for the next `BURST_LEN` cycles. The sample spacing counter restarts on open, re-arm and close. While the window is open, snapshots of type 2'b10 are produced every `BURST_PERIOD` cycles.
- R5: A valid event is written in the cycle it is presented, with type 2'b11. Its record holds the event code, temperature and policy state, and its peak and rise fields are 0. A periodic record has event code 0.
- R6: When an event and a periodic sample fall in the same cycle, only the event is written. `drop_cnt_o` then increments, saturating at all ones.
- R7: An event with `ev_irrev_i`=1 makes `ack_o` high for the following cycle. In that cycle the record is readable and `head_o` has already advanced.
- R8: The protection and recovery counts increment on `prot_i` and `recov_i` and saturate at all ones. The consecutive-failure count increments on `fail_i` and clears on `recov_i`, which takes priority over `fail_i`. Records hold the counter values from before that cycle's pulses.
- R9: Each periodic record stores a peak and a rise. The peak is the largest temperature seen since the previous sample instant, including the sampled cycle. The rise is the sampled temperature minus the previous sample's temperature, as modulo-2^TEMP_W two's complement, with the previous value 0 after reset. Dropped samples count as sample instants.
- R10: Each write goes to address `head_o`, after which `head_o` increments modulo `DEPTH`. `wrap_o` sets when address `DEPTH-1` is written and stays set. Older entries are overwritten.
- R11: The sequence number increments by one for each record written, modulo 2^SEQ_W.
- R12: The record layout, from MSB to LSB, is: sequence, time stamp, type, temperature, peak, rise, policy state, event code, protection count, recovery count, failure count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_i | input | TEMP_W | Current temperature sample |
| pstate_i | input | ST_W | Current thermal policy state |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_code_i | input | CODE_W | Event kind code |
| ev_crit_i | input | 1 | Event opens or re-arms the burst window |
| ev_irrev_i | input | 1 | Event precedes an irreversible action and needs an acknowledgement |
| prot_i | input | 1 | Protection activation pulse |
| recov_i | input | 1 | Recovery pulse |
| fail_i | input | 1 | Failure pulse |
| rd_addr_i | input | log2(DEPTH) | Read address |
| rd_data_o | output | REC_W | Record at the read address |
| head_o | output | log2(DEPTH) | Next write address |
| wrap_o | output | 1 | Buffer has wrapped at least once |
| burst_o | output | 1 | Burst window open |
| drop_cnt_o | output | DROP_W | Dropped periodic samples, saturating |
| ack_o | output | 1 | Evidence-done acknowledgement |

## Verification
The bench builds the block with `DEPTH`=8, `CNT_W`=3, `DROP_W`=3 and `BURST_LEN`=20, and keeps the default periods of 32 and 4. The small buffer wraps after eight records, so overwrite of the oldest entry shows up several times in one run. The 3-bit counters reach saturation after seven pulses or collisions, and a 20-cycle window yields five burst snapshots, which makes both the open and close transitions easy to observe. Directed cases force event/sample collisions and back-to-back irreversible events, and a seeded random stretch mixes all of the inputs.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
    typedef enum logic {
        WIN_BASE  = 1'b0,
        WIN_BURST = 1'b1
    } win_state_t;

    localparam logic [1:0] TYPE_BASE  = 2'b01;
    localparam logic [1:0] TYPE_BURST = 2'b10;
    localparam logic [1:0] TYPE_EVENT = 2'b11;
endpackage

// File: rtl/evlog_timebase.sv
module evlog_timebase
    import evlog_pkg::*;
#(
    parameter int TS_W         = 16,
    parameter int BASE_PERIOD  = 32,
    parameter int BURST_PERIOD = 4,
    parameter int BURST_LEN    = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            crit_i,
    output logic [TS_W-1:0] ts_o,
    output logic            tick_o,
    output logic            burst_o
);
    localparam int SC_W = $clog2(BASE_PERIOD + 1);
    localparam int BL_W = $clog2(BURST_LEN + 1);

    win_state_t      state_q, state_d;
    logic [BL_W-1:0] left_q, left_d;
    logic [SC_W-1:0] samp_q;
    logic [SC_W-1:0] period_lim;
    logic [TS_W-1:0] ts_q;

    // next-state logic of the window machine
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            WIN_BASE: begin
                if (crit_i) begin
                    state_d = WIN_BURST;
                    left_d  = BL_W'(BURST_LEN);
                end
            end
            WIN_BURST: begin
                if (crit_i) begin
                    left_d = BL_W'(BURST_LEN);
                end else if (left_q == BL_W'(1)) begin
                    state_d = WIN_BASE;
                    left_d  = '0;
                end else begin
                    left_d = left_q - BL_W'(1);
                end
            end
        endcase
    end

    // outputs of the window machine
    always_comb begin
        period_lim = (state_q == WIN_BURST) ? SC_W'(BURST_PERIOD - 1) : SC_W'(BASE_PERIOD - 1);
        tick_o     = (samp_q == period_lim);
        burst_o    = (state_q == WIN_BURST);
        ts_o       = ts_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_BASE;
            left_q  <= '0;
            samp_q  <= '0;
            ts_q    <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            ts_q    <= ts_q + TS_W'(1);
            if (tick_o || crit_i || (state_d != state_q))
                samp_q <= '0;
            else
                samp_q <= samp_q + SC_W'(1);
        end
    end

    assert_ts_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ts_o == TS_W'($past(ts_o) + TS_W'(1)));

    assert_crit_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crit_i |=> burst_o);

    assert_tick_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_q <= SC_W'(BASE_PERIOD - 1));
endmodule

// File: rtl/evlog_stats.sv
module evlog_stats #(
    parameter int TEMP_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              tick_i,
    input  logic              prot_i,
    input  logic              recov_i,
    input  logic              fail_i,
    output logic [TEMP_W-1:0] peak_o,
    output logic [TEMP_W-1:0] rise_o,
    output logic [CNT_W-1:0]  prot_cnt_o,
    output logic [CNT_W-1:0]  rec_cnt_o,
    output logic [CNT_W-1:0]  fail_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [TEMP_W-1:0] peak_q, prev_q;
    logic [CNT_W-1:0]  prot_q, rec_q, fail_q;

    always_comb begin
        peak_o     = (temp_i > peak_q) ? temp_i : peak_q;
        rise_o     = temp_i - prev_q;
        prot_cnt_o = prot_q;
        rec_cnt_o  = rec_q;
        fail_cnt_o = fail_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
            prev_q <= '0;
            prot_q <= '0;
            rec_q  <= '0;
            fail_q <= '0;
        end else begin
            if (tick_i) begin
                peak_q <= '0;
                prev_q <= temp_i;
            end else begin
                peak_q <= peak_o;
            end
            if (prot_i && prot_q != CNT_MAX) prot_q <= prot_q + CNT_W'(1);
            if (recov_i) begin
                if (rec_q != CNT_MAX) rec_q <= rec_q + CNT_W'(1);
                fail_q <= '0;
            end else if (fail_i && fail_q != CNT_MAX) begin
                fail_q <= fail_q + CNT_W'(1);
            end
        end
    end

    assert_fail_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recov_i |=> fail_cnt_o == '0);

    assert_prot_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_cnt_o == CNT_MAX) |=> prot_cnt_o == CNT_MAX);

    assert_peak_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o >= temp_i);
endmodule

// File: rtl/evlog_ram.sv
module evlog_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 67
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [W-1:0]             wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [W-1:0]             rdata_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/evlog_ring.sv
module evlog_ring
    import evlog_pkg::*;
#(
    parameter int TS_W         = 16,
    parameter int TEMP_W       = 8,
    parameter int ST_W         = 2,
    parameter int CODE_W       = 3,
    parameter int SEQ_W        = 8,
    parameter int CNT_W        = 4,
    parameter int DROP_W       = 8,
    parameter int DEPTH        = 16,
    parameter int BASE_PERIOD  = 32,
    parameter int BURST_PERIOD = 4,
    parameter int BURST_LEN    = 24,
    localparam int AW    = $clog2(DEPTH),
    localparam int PAY_W = 3 * TEMP_W + ST_W + CODE_W + 3 * CNT_W,
    localparam int REC_W = SEQ_W + TS_W + 2 + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [ST_W-1:0]   pstate_i,
    input  logic              ev_valid_i,
    input  logic [CODE_W-1:0] ev_code_i,
    input  logic              ev_crit_i,
    input  logic              ev_irrev_i,
    input  logic              prot_i,
    input  logic              recov_i,
    input  logic              fail_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [REC_W-1:0]  rd_data_o,
    output logic [AW-1:0]     head_o,
    output logic              wrap_o,
    output logic              burst_o,
    output logic [DROP_W-1:0] drop_cnt_o,
    output logic              ack_o
);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    logic [TS_W-1:0]   ts;
    logic              tick;
    logic [TEMP_W-1:0] peak, rise;
    logic [CNT_W-1:0]  prot_cnt, rec_cnt, fail_cnt;
    logic              wr_en;
    logic [REC_W-1:0]  rec;
    logic [AW-1:0]     head_q;
    logic [SEQ_W-1:0]  seq_q;
    logic              wrap_q, ack_q;
    logic [DROP_W-1:0] drop_q;

    evlog_timebase #(
        .TS_W(TS_W), .BASE_PERIOD(BASE_PERIOD),
        .BURST_PERIOD(BURST_PERIOD), .BURST_LEN(BURST_LEN)
    ) u_time (
        .clk(clk), .rst_n(rst_n), .crit_i(ev_valid_i && ev_crit_i),
        .ts_o(ts), .tick_o(tick), .burst_o(burst_o)
    );

    evlog_stats #(.TEMP_W(TEMP_W), .CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .tick_i(tick),
        .prot_i(prot_i), .recov_i(recov_i), .fail_i(fail_i),
        .peak_o(peak), .rise_o(rise),
        .prot_cnt_o(prot_cnt), .rec_cnt_o(rec_cnt), .fail_cnt_o(fail_cnt)
    );

    evlog_ram #(.DEPTH(DEPTH), .W(REC_W)) u_ram (
        .clk(clk), .we_i(wr_en), .waddr_i(head_q), .wdata_i(rec),
        .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
    );

    always_comb begin
        wr_en = ev_valid_i || tick;
        if (ev_valid_i)
            rec = {seq_q, ts, TYPE_EVENT, temp_i, TEMP_W'(0), TEMP_W'(0),
                   pstate_i, ev_code_i, prot_cnt, rec_cnt, fail_cnt};
        else
            rec = {seq_q, ts, (burst_o ? TYPE_BURST : TYPE_BASE), temp_i, peak, rise,
                   pstate_i, CODE_W'(0), prot_cnt, rec_cnt, fail_cnt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            seq_q  <= '0;
            wrap_q <= 1'b0;
            drop_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                head_q <= head_q + AW'(1);
                seq_q  <= seq_q + SEQ_W'(1);
                if (head_q == AW'(DEPTH - 1)) wrap_q <= 1'b1;
            end
            if (ev_valid_i && tick && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
            ack_q <= ev_valid_i && ev_irrev_i;
        end
    end

    assign head_o     = head_q;
    assign wrap_o     = wrap_q;
    assign drop_cnt_o = drop_q;
    assign ack_o      = ack_q;

    assert_ack_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> head_o == AW'($past(head_o) + AW'(1)));

    assert_drop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_i && tick) |=> (drop_cnt_o == DROP_W'($past(drop_cnt_o) + DROP_W'(1)))
                                 || (drop_cnt_o == DROP_MAX));

    assert_wrap_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> wrap_o);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid_i || tick) |=> $stable(head_o));
endmodule

// File: tb/tb_evlog_ring.sv
module tb_evlog_ring;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 8, CNT_W = 3, DROP_W = 3, BURST_LEN = 20;
    localparam int BAP = 32, BP = 4;
    localparam int AW = 3, REC_W = 64;
    localparam int OFF_PROT = 2 * CNT_W, OFF_REC = CNT_W, OFF_CODE = 3 * CNT_W;
    localparam int OFF_ST = OFF_CODE + 3, OFF_RISE = OFF_ST + 2, OFF_PEAK = OFF_RISE + 8;
    localparam int OFF_TEMP = OFF_PEAK + 8, OFF_TYPE = OFF_TEMP + 8;
    localparam int OFF_TS = OFF_TYPE + 2, OFF_SEQ = OFF_TS + 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] temp = 8'd40;
    logic [1:0] pst = '0;
    logic [2:0] code = '0;
    logic ev = 0, crit = 0, irrev = 0, prot = 0, recov = 0, fail = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [REC_W-1:0] rd_data;
    logic [AW-1:0] head;
    logic wrap, burst, ack;
    logic [DROP_W-1:0] drop;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_ts = '0;
    logic [7:0]  m_seq = '0, m_peak = '0, m_prev = '0;
    int m_samp = 0, m_left = 0, m_prot = 0, m_rec = 0, m_fail = 0, m_head = 0, m_drop = 0;
    bit m_burst = 0, m_wrap = 0, m_ack = 0;

    evlog_ring #(.CNT_W(CNT_W), .DROP_W(DROP_W), .DEPTH(DEPTH), .BASE_PERIOD(BAP),
                 .BURST_PERIOD(BP), .BURST_LEN(BURST_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .temp_i(temp), .pstate_i(pst),
        .ev_valid_i(ev), .ev_code_i(code), .ev_crit_i(crit), .ev_irrev_i(irrev),
        .prot_i(prot), .recov_i(recov), .fail_i(fail), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .head_o(head), .wrap_o(wrap), .burst_o(burst),
        .drop_cnt_o(drop), .ack_o(ack)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] fld(input logic [63:0] r, input int off, input int w);
        return (r >> off) & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic bit tick_pending();
        return m_samp == ((m_burst ? BP : BAP) - 1);
    endfunction

    // one clock cycle: model step, edge, then compare
    task automatic cyc();
        int per, waddr;
        bit tk, ce, wr, ex;
        logic [7:0] pk, rs;
        logic [1:0] typ;
        logic [63:0] erec;
        string rt;
        per = m_burst ? BP : BAP;
        tk = (m_samp == per - 1);
        ce = ev && crit;
        pk = (temp > m_peak) ? temp : m_peak;
        rs = temp - m_prev;
        wr = ev || tk;
        waddr = m_head;
        if (ev) begin
            typ = 2'b11;
            erec = {m_seq, m_ts, typ, temp, 8'h0, 8'h0, pst, code, 3'(m_prot), 3'(m_rec), 3'(m_fail)};
        end else begin
            typ = m_burst ? 2'b10 : 2'b01;
            erec = {m_seq, m_ts, typ, temp, pk, rs, pst, 3'b0, 3'(m_prot), 3'(m_rec), 3'(m_fail)};
        end
        if (ev && tk && m_drop < 7) m_drop++;
        if (wr) begin
            if (m_head == DEPTH - 1) m_wrap = 1;
            m_head = (m_head + 1) % DEPTH;
            m_seq = m_seq + 8'd1;
        end
        m_ack = ev && irrev;
        ex = m_burst && !ce && m_left == 1;
        if (tk || ce || ex || (!m_burst && ce)) m_samp = 0; else m_samp++;
        if (ce) begin m_burst = 1; m_left = BURST_LEN; end
        else if (m_burst) begin
            if (m_left == 1) begin m_burst = 0; m_left = 0; end else m_left--;
        end
        if (tk) begin m_peak = 8'h0; m_prev = temp; end else m_peak = pk;
        if (prot && m_prot < 7) m_prot++;
        if (recov) begin if (m_rec < 7) m_rec++; m_fail = 0; end
        else if (fail && m_fail < 7) m_fail++;
        m_ts = m_ts + 16'd1;

        @(posedge clk);
        @(negedge clk);
        chk("R10", "head", 64'(head), 64'(m_head));
        chk("R10", "wrap", 64'(wrap), 64'(m_wrap));
        chk("R6", "drop count", 64'(drop), 64'(m_drop));
        chk("R7", "ack", 64'(ack), 64'(m_ack));
        chk("R4", "burst window", 64'(burst), 64'(m_burst));
        if (wr) begin
            rd_addr = AW'(waddr);
            #1;
            rt = (typ == 2'b11) ? "R5" : ((typ == 2'b10) ? "R4" : "R3");
            chk(rt, "record type", fld(rd_data, OFF_TYPE, 2), fld(erec, OFF_TYPE, 2));
            chk("R2", "time stamp", fld(rd_data, OFF_TS, 16), fld(erec, OFF_TS, 16));
            chk("R11", "sequence", fld(rd_data, OFF_SEQ, 8), fld(erec, OFF_SEQ, 8));
            chk("R5", "temp/state/code", fld(rd_data, OFF_CODE, 13), fld(erec, OFF_CODE, 13));
            chk("R9", "peak", fld(rd_data, OFF_PEAK, 8), fld(erec, OFF_PEAK, 8));
            chk("R9", "rise", fld(rd_data, OFF_RISE, 8), fld(erec, OFF_RISE, 8));
            chk("R8", "counters", fld(rd_data, 0, 3 * CNT_W), fld(erec, 0, 3 * CNT_W));
            chk("R12", "whole record", rd_data, erec);
        end
    endtask

    task automatic quiet();
        ev = 0; crit = 0; irrev = 0; prot = 0; recov = 0; fail = 0; code = '0;
    endtask

    initial begin
        int r;
        r = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk("R1", "head after reset", 64'(head), 64'd0);
        chk("R1", "wrap after reset", 64'(wrap), 64'd0);
        chk("R1", "burst after reset", 64'(burst), 64'd0);
        chk("R1", "drop after reset", 64'(drop), 64'd0);
        chk("R1", "ack after reset", 64'(ack), 64'd0);
        rst_n = 1'b1;

        // R3: base rate snapshots with rising temperature for R9 peak
        for (int i = 0; i < 70; i++) begin
            temp = 8'(40 + (i % 9));
            cyc();
        end
        // R4: critical event opens a window, let it close
        ev = 1; crit = 1; code = 3'd2; cyc(); quiet();
        for (int i = 0; i < 30; i++) cyc();
        // R4: re-arm inside the window
        ev = 1; crit = 1; code = 3'd3; cyc(); quiet();
        for (int i = 0; i < 10; i++) cyc();
        ev = 1; crit = 1; code = 3'd3; cyc(); quiet();
        for (int i = 0; i < 25; i++) cyc();
        // R6: force collisions until the drop counter saturates
        for (int k = 0; k < 9; k++) begin
            while (!tick_pending()) cyc();
            ev = 1; code = 3'd5; cyc(); quiet();
        end
        // R7: single and back-to-back irreversible events
        ev = 1; irrev = 1; code = 3'd6; cyc(); quiet(); cyc();
        ev = 1; irrev = 1; code = 3'd7; cyc();
        ev = 1; irrev = 1; code = 3'd1; cyc(); quiet(); cyc();
        // R8: saturate counters, fail then clear by recovery
        for (int i = 0; i < 10; i++) begin prot = 1; fail = 1; cyc(); end
        quiet(); ev = 1; code = 3'd4; cyc(); quiet();
        recov = 1; fail = 1; cyc(); quiet(); ev = 1; cyc(); quiet();
        // random mix
        for (int i = 0; i < 4000; i++) begin
            temp  = temp + 8'($urandom % 7) - 8'd3;
            pst   = 2'($urandom % 4);
            ev    = ($urandom % 10) == 0;
            code  = 3'($urandom % 8);
            crit  = ($urandom % 4) == 0;
            irrev = ($urandom % 2) == 0;
            prot  = ($urandom % 25) == 0;
            recov = ($urandom % 40) == 0;
            fail  = ($urandom % 15) == 0;
            cyc();
        end
        quiet();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule